// File: doc/BRIEF.md
# Page Root Counter Prediction Table

This block keeps one shared base counter ("root") for each page tracked by the address-translation entries of a secure memory controller. Every memory line of a page starts its encryption counter from that page's root. A predictor uses the root to guess line counters. A lookup port returns the current root of any entry in the same cycle, so the guesses can be pre-computed while the line itself is still being fetched.

The verifier that later learns the true counter reports each guess as a hit or a miss. Each entry shifts those outcomes into a 16-bit history window. If too many misses accumulate in the window, the guessing scheme has stopped working for that page. The entry then takes a fresh root from an internal seed register, its history is wiped, and a one-cycle pulse names the renewed entry so that the surrounding logic can re-encrypt the page.

Allocating an entry, which happens when a translation entry is refilled, also draws a fresh root from the seed. The seed register advances on every draw, so no two roots are handed out with the same value unless software reloads the seed.

Top module: `page_root_predictor`

## Requirements
- R1: After reset every entry's root and history read as zero, `renew_pulse` is low, and the seed register holds the parameter `SEED_INIT`.
- R2: When `alloc_valid` is high, the entry `alloc_idx` takes the current seed as its root and clears its history. The new root is visible on the lookup port from the next cycle.
- R3: `lookup_root` shows the root of entry `lookup_idx` combinationally. If a write to that entry happens in the same cycle, the lookup returns the value from before the write.
- R4: Each effective outcome report shifts one bit into the 16-bit history of `rep_idx`: 1 for a miss (`rep_miss`=1) and 0 for a hit. The newest bit enters at bit 0 and the oldest bit at bit 15 is dropped.
- R5: A report renews its entry when the number of ones in the shifted history is strictly greater than `cfg_threshold`. On renewal the entry's root becomes a seed value and its history is cleared to zero.
- R6: A renewal raises `renew_pulse` for exactly one cycle, starting in the cycle after the report, with `renew_idx` set to the reported entry.
- R7: The seed rises by one for each value drawn in a cycle. If an allocation and a renewal happen in the same cycle, the allocation gets the seed and the renewal gets the seed plus one, and the seed rises by two.
- R8: An outcome report to the same entry as a simultaneous allocation is ignored. It neither shifts history nor renews.
- R9: `seed_load` replaces the seed with `seed_value` at the clock edge. It overrides any increment in that cycle, and the loaded value is the next one drawn.
- R10: With `cfg_threshold` at 16 or above no renewal can occur, since a 16-bit history never holds more than 16 ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry with a fresh root |
| alloc_idx | input | 6 | Entry to allocate |
| rep_valid | input | 1 | Outcome report present |
| rep_idx | input | 6 | Entry the report concerns |
| rep_miss | input | 1 | 1 = prediction missed, 0 = hit |
| cfg_threshold | input | 5 | Miss count the history must exceed to renew |
| seed_load | input | 1 | Reload the seed register |
| seed_value | input | 64 | Value loaded into the seed register |
| lookup_idx | input | 6 | Entry to read |
| lookup_root | output | 64 | Root of entry `lookup_idx` |
| renew_pulse | output | 1 | One-cycle pulse after a renewal |
| renew_idx | output | 6 | Entry renewed |

## Verification
Directed sequences first build a miss run on one entry at a low threshold. This shows whether the strict greater-than compare fires on exactly the right report, and whether the cleared history then needs a full new run before the next renewal. Other directed cases place an allocation and a report on the same entry, and on different entries, in one cycle. These separate the report-drop rule from the two-draw seed ordering, and a seed load combined with a draw shows which one wins. Random traffic then runs over a few hot entries with mixed hit rates and thresholds, some of them at or above 16. This exercises the sliding window, where old misses age out, and shows that high thresholds never renew. All results are compared against a bench model.

// File: rtl/prt_pkg.sv
package prt_pkg;
  parameter int HIST_W = 16;
  parameter int CNT_W  = $clog2(HIST_W + 1);

  typedef logic [HIST_W-1:0] hist_t;

  // number of recorded misses in a history window
  function automatic logic [CNT_W-1:0] miss_count(input hist_t h);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < HIST_W; i++) n = n + CNT_W'(h[i]);
    return n;
  endfunction

  // newest outcome enters at bit 0, oldest drops off the top
  function automatic hist_t push_outcome(input hist_t h, input logic miss);
    return {h[HIST_W-2:0], miss};
  endfunction
endpackage

// File: rtl/prt_seed_gen.sv
module prt_seed_gen #(
  parameter int             ROOT_W    = 64,
  parameter logic [63:0]    SEED_INIT = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        use_cnt,
  input  logic              load,
  input  logic [ROOT_W-1:0] load_val,
  output logic [ROOT_W-1:0] seed_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    seed_q <= SEED_INIT[ROOT_W-1:0];
    else if (load) seed_q <= load_val;
    else           seed_q <= seed_q + ROOT_W'(use_cnt);
  end

  // R7: each draw moves the seed by one unless a load intervenes
  p_seed_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && use_cnt != 2'd0) |=> (seed_q == $past(seed_q) + ROOT_W'($past(use_cnt))));
  // R9: a load wins over any increment
  p_seed_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (seed_q == $past(load_val)));
endmodule

// File: rtl/prt_hist_update.sv
module prt_hist_update
  import prt_pkg::*;
#(
  parameter int THR_W = 5
) (
  input  hist_t             hist_cur,
  input  logic              miss,
  input  logic [THR_W-1:0]  threshold,
  output hist_t             hist_nxt,
  output logic              over_limit
);
  logic [CNT_W-1:0] n_miss;
  always_comb begin
    hist_nxt   = push_outcome(hist_cur, miss);
    n_miss     = miss_count(hist_nxt);
    over_limit = (32'(n_miss) > 32'(threshold));
  end
endmodule

// File: rtl/page_root_predictor.sv
module page_root_predictor
  import prt_pkg::*;
#(
  parameter int          N_ENTRIES = 64,
  parameter int          ROOT_W    = 64,
  parameter int          THR_W     = 5,
  parameter logic [63:0] SEED_INIT = 64'h1,
  localparam int         IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [IDX_W-1:0]  alloc_idx,
  input  logic              rep_valid,
  input  logic [IDX_W-1:0]  rep_idx,
  input  logic              rep_miss,
  input  logic [THR_W-1:0]  cfg_threshold,
  input  logic              seed_load,
  input  logic [ROOT_W-1:0] seed_value,
  input  logic [IDX_W-1:0]  lookup_idx,
  output logic [ROOT_W-1:0] lookup_root,
  output logic              renew_pulse,
  output logic [IDX_W-1:0]  renew_idx
);
  logic [ROOT_W-1:0] root_mem [N_ENTRIES];
  hist_t             hist_mem [N_ENTRIES];

  logic [ROOT_W-1:0] seed_q;
  logic              rep_eff;     // report survives the allocation clash rule
  logic              renew_ev;    // renewal decided this cycle
  hist_t             hist_nxt;
  logic              over_limit;
  logic [ROOT_W-1:0] renew_root;
  logic [1:0]        use_cnt;

  assign rep_eff    = rep_valid && !(alloc_valid && alloc_idx == rep_idx);
  assign renew_ev   = rep_eff && over_limit;
  assign renew_root = alloc_valid ? seed_q + ROOT_W'(1) : seed_q;
  assign use_cnt    = 2'(alloc_valid) + 2'(renew_ev);

  prt_hist_update #(.THR_W(THR_W)) u_upd (
    .hist_cur   (hist_mem[rep_idx]),
    .miss       (rep_miss),
    .threshold  (cfg_threshold),
    .hist_nxt   (hist_nxt),
    .over_limit (over_limit)
  );

  prt_seed_gen #(.ROOT_W(ROOT_W), .SEED_INIT(SEED_INIT)) u_seed (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_cnt  (use_cnt),
    .load     (seed_load),
    .load_val (seed_value),
    .seed_q   (seed_q)
  );

  assign lookup_root = root_mem[lookup_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENTRIES; i++) begin
        root_mem[i] <= '0;
        hist_mem[i] <= '0;
      end
      renew_pulse <= 1'b0;
      renew_idx   <= '0;
    end else begin
      if (rep_eff) begin
        if (renew_ev) begin
          root_mem[rep_idx] <= renew_root;
          hist_mem[rep_idx] <= '0;
        end else begin
          hist_mem[rep_idx] <= hist_nxt;
        end
      end
      if (alloc_valid) begin
        root_mem[alloc_idx] <= seed_q;
        hist_mem[alloc_idx] <= '0;
      end
      renew_pulse <= renew_ev;
      renew_idx   <= rep_idx;
    end
  end

  // R5: a renewed entry starts with an empty window
  p_renew_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    renew_pulse |-> (hist_mem[renew_idx] == '0));
  // R6: a pulse follows a report to the same entry
  p_pulse_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    renew_pulse |-> ($past(rep_valid) && renew_idx == $past(rep_idx)));
  // R8: a report clashing with an allocation never renews
  p_clash_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rep_valid && alloc_valid && rep_idx == alloc_idx) |=> !renew_pulse);
  // R10: thresholds beyond the window size never renew
  p_high_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cfg_threshold) >= HIST_W) |=> !renew_pulse);
  // R2: allocated entry reads the drawn seed next cycle
  p_alloc_root_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> (root_mem[$past(alloc_idx)] == $past(seed_q)));
endmodule

// File: tb/tb_page_root_predictor.sv
`timescale 1ns/1ps
module tb_page_root_predictor;
  localparam int N = 64;
  localparam logic [63:0] SEED0 = 64'h1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, rep_valid = 0, rep_miss = 0, seed_load = 0;
  logic [5:0] alloc_idx = 0, rep_idx = 0, lookup_idx = 0;
  logic [4:0] cfg_threshold = 0;
  logic [63:0] seed_value = 0;
  logic [63:0] lookup_root;
  logic renew_pulse;
  logic [5:0] renew_idx;

  always #2.5 clk = ~clk;

  page_root_predictor #(.SEED_INIT(SEED0)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .rep_valid(rep_valid), .rep_idx(rep_idx), .rep_miss(rep_miss),
    .cfg_threshold(cfg_threshold), .seed_load(seed_load), .seed_value(seed_value),
    .lookup_idx(lookup_idx), .lookup_root(lookup_root),
    .renew_pulse(renew_pulse), .renew_idx(renew_idx));

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] m_root [N];
  logic [15:0] m_hist [N];
  logic [63:0] m_seed;

  function automatic int ones(input logic [15:0] h);
    int c = 0;
    for (int i = 0; i < 16; i++) if (h[i]) c++;
    return c;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle of stimulus: drive at negedge, check lookup pre-update,
  // advance the model, then check pulse and renewed root after the edge
  task automatic step(input bit av, input int ai, input bit rv, input int ri,
                      input bit rm, input int li, input bit ld, input logic [63:0] ldv,
                      input int thr, input string req);
    logic [15:0] hn;
    bit eff, ren;
    logic [63:0] s;
    @(negedge clk);
    alloc_valid = av; alloc_idx = 6'(ai); rep_valid = rv; rep_idx = 6'(ri);
    rep_miss = rm; lookup_idx = 6'(li); seed_load = ld; seed_value = ldv;
    cfg_threshold = 5'(thr);
    #1;
    chk({req, "/R3 lookup"}, lookup_root, m_root[li]);
    eff = rv && !(av && ai == ri);
    hn  = {m_hist[ri][14:0], rm};
    ren = eff && (ones(hn) > thr);
    s   = m_seed;
    if (eff) begin
      if (ren) begin m_root[ri] = av ? s + 1 : s; m_hist[ri] = 0; end
      else m_hist[ri] = hn;
    end
    if (av) begin m_root[ai] = s; m_hist[ai] = 0; end
    m_seed = ld ? ldv : s + 64'(av) + 64'(ren);
    @(posedge clk);
    #1;
    alloc_valid = 0; rep_valid = 0; seed_load = 0;
    chk({req, "/R6 pulse"}, 64'(renew_pulse), 64'(ren));
    if (ren) begin
      chk({req, "/R6 idx"}, 64'(renew_idx), 64'(ri));
      lookup_idx = 6'(ri);
      #0.5;
      chk({req, "/R5 root"}, lookup_root, m_root[ri]);
    end
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_cmp++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_root[i] = 0; m_hist[i] = 0; end
    m_seed = SEED0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state
    #1 chk("R1 pulse", 64'(renew_pulse), 0);
    for (int i = 0; i < N; i += 21) begin
      lookup_idx = 6'(i); #0.5; chk("R1 root", lookup_root, 0);
    end
    // R2/R1: allocation draws the reset seed, visible next cycle
    step(1, 5, 0, 0, 0, 5, 0, 0, 31, "R2 alloc");
    step(0, 0, 0, 0, 0, 5, 0, 0, 31, "R2 readback");
    chk("R1 seed", lookup_root, SEED0);
    // R4/R5: threshold 2, third miss renews
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R4 miss1");
    step(0, 0, 1, 5, 0, 5, 0, 0, 2, "R4 hit");
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R5 miss2 no renew");
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R5 miss3 renew");
    // after clear, two misses are not enough
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R5 cleared a");
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R5 cleared b");
    // R3: lookup in the write cycle shows old root
    step(0, 0, 1, 5, 1, 5, 0, 0, 2, "R3 same-cycle renew");
    // R8: clash report dropped
    step(1, 9, 1, 9, 1, 9, 0, 0, 0, "R8 clash");
    step(0, 0, 0, 0, 0, 9, 0, 0, 0, "R8 after");
    // R7: alloc and renew together on different entries
    step(1, 11, 1, 9, 1, 11, 0, 0, 0, "R7 dual draw");
    step(0, 0, 0, 0, 0, 11, 0, 0, 0, "R7 alloc root");
    step(0, 0, 0, 0, 0, 9, 0, 0, 0, "R7 renew root");
    // R9: load overrides a draw in the same cycle
    step(1, 12, 0, 0, 0, 12, 1, 64'hdead_beef_0000_0000, 31, "R9 load+draw");
    step(1, 13, 0, 0, 0, 12, 0, 0, 31, "R9 next draw");
    step(0, 0, 0, 0, 0, 13, 0, 0, 31, "R9 loaded root");
    // R10: sixteen misses at threshold 16 never renew, 15 then renews
    for (int k = 0; k < 18; k++) step(0, 0, 1, 20, 1, 20, 0, 0, 16, "R10 high thr");
    step(0, 0, 1, 20, 1, 20, 0, 0, 15, "R10 drop to 15");
    // random traffic over hot entries
    for (int k = 0; k < 3000; k++) begin
      int hot, thr;
      bit miss;
      hot  = ($urandom % 4 == 0) ? int'($urandom % N) : int'($urandom % 4);
      miss = ($urandom % 100) < ((hot % 4) * 25 + 20);
      thr  = ($urandom % 8 == 0) ? int'(16 + $urandom % 16) : int'($urandom % 8);
      step($urandom % 10 == 0, int'($urandom % 6), $urandom % 4 != 0, hot, miss,
           int'($urandom % 6), $urandom % 200 == 0, {$urandom, $urandom}, thr, "R4 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule